// File: doc/BRIEF.md
# Inbound Doorbell Queue Controller

This block accepts doorbell events from a serial-link receiver and stores them in a circular ring held in local memory. Each event carries a source identifier, a target identifier and a 16-bit info word. Every accepted event becomes one 8-byte entry made of four halfwords. Listed from the lowest byte address, these are a zero pad, the target identifier, the source identifier and the info word. In the 64-bit entry this puts the pad in bits 63:48, the target in 47:32, the source in 31:16 and the info word in 15:0. The ring is 4 KB by default, which is 512 entries.

Software controls the block through four 32-bit registers, selected by a 2-bit word index:

| Index | Register |
|-------|----------|
| 0 | mode |
| 1 | status |
| 2 | dequeue pointer |
| 3 | enqueue pointer |

Software reads queued entries through a separate ring read port. The low 12 bits of each pointer hold the byte offset of an entry, and the upper bits hold the ring base. To release the head entry, software writes the self-clearing dequeue-increment command. A single interrupt line is raised while any status flag is set.

A typical sequence has four steps:

1. With the unit disabled, load both pointers with the ring base.
2. Enable the unit.
3. On each interrupt, read the entry at the dequeue offset.
4. Advance the dequeue pointer and clear the flags.

Top module: `dbell_queue`

## Requirements
- R1: After reset, the mode, status, dequeue pointer and enqueue pointer registers all read 0, and `irq` is 0.
- R2: An accepted doorbell is written into the ring slot indexed by bits 11:3 of the enqueue pointer, using the layout {pad=0, target, source, info} from bit 63 down to bit 0. The ring read port returns that slot one clock after its index is presented.
- R3: Each accepted doorbell advances the enqueue pointer by 8. The low 12 bits wrap modulo 4096, and bits 31:12 keep their value.
- R4: Writing the mode register (index 0) with bit 1 set advances the dequeue pointer by 8, with the same wrap, but only when the unit is enabled and the pointers differ. Bit 1 is never stored and always reads as 0. Bit 0 is the enable bit.
- R5: Status bit 0 (entry-in-queue) is set on every clock in which the two pointers differ. A write-one-to-clear on this bit shows 0 for one clock and the bit is set again on the following clock if entries remain.
- R6: The ring holds at most 511 entries. A doorbell that arrives while the ring is full is dropped: the enqueue pointer and the ring contents are unchanged, and status bit 4 (queue full) is set.
- R7: A reception-error pulse on `db_err` while the unit is enabled sets status bit 7.
- R8: Status bits 7, 4 and 0 are write-one-to-clear through register index 1. Writing 0 to a bit leaves it unchanged, and writing 0x91 clears all three.
- R9: While the unit is disabled, doorbells, errors and dequeue commands are ignored. Writes to the pointer registers (indices 2 and 3, with bits 2:0 forced to 0) take effect only while the unit is disabled.
- R10: `irq` is 1 exactly when at least one of the three status flags is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_valid | input | 1 | Doorbell present this cycle |
| db_src | input | 16 | Doorbell source identifier |
| db_tgt | input | 16 | Doorbell target identifier |
| db_info | input | 16 | Doorbell info word |
| db_err | input | 1 | Reception error pulse |
| reg_wen | input | 1 | Register write strobe |
| reg_word | input | 2 | Register index (0 mode, 1 status, 2 dequeue, 3 enqueue) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` (combinational) |
| ring_ridx | input | 9 | Ring slot index to read |
| ring_rdata | output | 64 | Ring slot contents, one clock after the index |
| irq | output | 1 | Any status flag set |

## Verification
The checker watches four rules on every cycle:

- A doorbell that arrives with the ring full leaves the enqueue pointer unchanged and sets the full flag.
- An accepted doorbell moves the pointer by exactly one entry.
- Differing pointers set the entry-in-queue flag.
- A disabled unit leaves both pointers unchanged unless software writes them.

Some behaviour only the bench scenarios can show: the layout of stored entries, the one-clock gap when a pending entry flag is cleared, pointer wrap at the 4 KB boundary with the base bits kept, and the 511-entry capacity with the dropped doorbell leaving the spare slot untouched.

// File: rtl/dbell_queue_pkg.sv
package dbell_queue_pkg;

    localparam int ENTRY_BYTES = 8;
    localparam int HW          = 16;

    // Status flag positions (software decodes these)
    localparam int STAT_EIQ  = 0;
    localparam int STAT_FULL = 4;
    localparam int STAT_ERR  = 7;

    // Mode bit positions
    localparam int MODE_EN  = 0;
    localparam int MODE_DEQ = 1;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_STAT = 2'd1,
        REG_DEQ  = 2'd2,
        REG_ENQ  = 2'd3
    } reg_sel_e;

    // Highest halfword sits at the lowest byte address
    typedef struct packed {
        logic [HW-1:0] pad;
        logic [HW-1:0] tgt;
        logic [HW-1:0] src;
        logic [HW-1:0] info;
    } dbell_entry_t;

    function automatic dbell_entry_t pack_entry(
        input logic [HW-1:0] src,
        input logic [HW-1:0] tgt,
        input logic [HW-1:0] info
    );
        dbell_entry_t e;
        e.pad  = '0;
        e.tgt  = tgt;
        e.src  = src;
        e.info = info;
        return e;
    endfunction

endpackage

// File: rtl/dbell_queue_ring.sv
module dbell_queue_ring
    import dbell_queue_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  dbell_entry_t     wdata,
    input  logic [IDX_W-1:0] ridx,
    output dbell_entry_t     rdata
);

    dbell_entry_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
        rdata <= mem[ridx];
    end

endmodule

// File: rtl/dbell_queue_ctrl.sv
module dbell_queue_ctrl
    import dbell_queue_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        db_valid,
    input  logic        db_err,
    input  logic        reg_wen,
    input  reg_sel_e    reg_sel,
    input  logic [31:0] reg_wdata,
    output logic        en,
    output logic        full,
    output logic        store,
    output logic        eiq,
    output logic        qfull,
    output logic        rxerr,
    output logic [31:0] enq_ptr,
    output logic [31:0] deq_ptr
);

    localparam logic [OFS_W-1:0] STEP = OFS_W'(ENTRY_BYTES);

    function automatic logic [31:0] advance(input logic [31:0] p);
        return {p[31:OFS_W], p[OFS_W-1:0] + STEP};
    endfunction

    logic [31:0] wr_aligned;
    logic        nonempty, deq_inc;
    logic        mode_wr, stat_wr, enq_wr, deq_wr;
    logic        clr_eiq, clr_full, clr_err;

    assign wr_aligned = reg_wdata & ~32'd7;
    assign nonempty   = (enq_ptr != deq_ptr);
    assign full       = (advance(enq_ptr) == deq_ptr);
    assign store      = db_valid && en && !full;

    assign mode_wr = reg_wen && (reg_sel == REG_MODE);
    assign stat_wr = reg_wen && (reg_sel == REG_STAT);
    assign enq_wr  = reg_wen && (reg_sel == REG_ENQ) && !en;
    assign deq_wr  = reg_wen && (reg_sel == REG_DEQ) && !en;
    assign deq_inc = mode_wr && reg_wdata[MODE_DEQ] && en && nonempty;

    assign clr_eiq  = stat_wr && reg_wdata[STAT_EIQ];
    assign clr_full = stat_wr && reg_wdata[STAT_FULL];
    assign clr_err  = stat_wr && reg_wdata[STAT_ERR];

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            enq_ptr <= '0;
            deq_ptr <= '0;
            eiq     <= 1'b0;
            qfull   <= 1'b0;
            rxerr   <= 1'b0;
        end else begin
            if (mode_wr) begin
                en <= reg_wdata[MODE_EN];
            end

            if (store) begin
                enq_ptr <= advance(enq_ptr);
            end else if (enq_wr) begin
                enq_ptr <= wr_aligned;
            end

            if (deq_inc) begin
                deq_ptr <= advance(deq_ptr);
            end else if (deq_wr) begin
                deq_ptr <= wr_aligned;
            end

            // A clear wins over a set in the same cycle
            eiq   <= clr_eiq  ? 1'b0 : (eiq   | nonempty);
            qfull <= clr_full ? 1'b0 : (qfull | (db_valid && en && full));
            rxerr <= clr_err  ? 1'b0 : (rxerr | (db_err && en));
        end
    end

endmodule

// File: rtl/dbell_queue.sv
module dbell_queue
    import dbell_queue_pkg::*;
#(
    parameter int RING_ENTRIES = 512,
    localparam int IDX_W       = $clog2(RING_ENTRIES),
    localparam int OFS_W       = IDX_W + $clog2(ENTRY_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             db_valid,
    input  logic [HW-1:0]    db_src,
    input  logic [HW-1:0]    db_tgt,
    input  logic [HW-1:0]    db_info,
    input  logic             db_err,
    input  logic             reg_wen,
    input  logic [1:0]       reg_word,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [IDX_W-1:0] ring_ridx,
    output logic [63:0]      ring_rdata,
    output logic             irq
);

    reg_sel_e     reg_sel;
    logic         mode_en, ring_full, store;
    logic         f_eiq, f_full, f_err;
    logic [31:0]  enq_ptr, deq_ptr;
    logic [7:0]   status_vec;
    dbell_entry_t wr_entry, rd_entry;

    assign reg_sel  = reg_sel_e'(reg_word);
    assign wr_entry = pack_entry(db_src, db_tgt, db_info);

    dbell_queue_ctrl #(
        .OFS_W(OFS_W)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .db_valid (db_valid),
        .db_err   (db_err),
        .reg_wen  (reg_wen),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .en       (mode_en),
        .full     (ring_full),
        .store    (store),
        .eiq      (f_eiq),
        .qfull    (f_full),
        .rxerr    (f_err),
        .enq_ptr  (enq_ptr),
        .deq_ptr  (deq_ptr)
    );

    dbell_queue_ring #(
        .ENTRIES(RING_ENTRIES)
    ) ring_i (
        .clk  (clk),
        .we   (store),
        .widx (enq_ptr[OFS_W-1:3]),
        .wdata(wr_entry),
        .ridx (ring_ridx),
        .rdata(rd_entry)
    );

    always_comb begin
        status_vec            = '0;
        status_vec[STAT_EIQ]  = f_eiq;
        status_vec[STAT_FULL] = f_full;
        status_vec[STAT_ERR]  = f_err;
    end

    always_comb begin
        case (reg_sel)
            REG_MODE: reg_rdata = {31'b0, mode_en};
            REG_STAT: reg_rdata = {24'b0, status_vec};
            REG_DEQ:  reg_rdata = deq_ptr;
            default:  reg_rdata = enq_ptr;
        endcase
    end

    assign ring_rdata = rd_entry;
    assign irq        = f_eiq | f_full | f_err;

endmodule

// File: rtl/dbell_queue_chk.sv
module dbell_queue_chk #(
    parameter int OFS_W = 12
) (
    input logic        clk,
    input logic        rst,
    input logic        db_valid,
    input logic        db_err,
    input logic        reg_wen,
    input logic        en,
    input logic        full,
    input logic        eiq,
    input logic        qfull,
    input logic        rxerr,
    input logic [31:0] enq_ptr,
    input logic [31:0] deq_ptr
);

    localparam logic [OFS_W-1:0] STEP = OFS_W'(8);

    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (db_valid && en && full) |=> $stable(enq_ptr)); // R6

    AST_QFULL_SET: assert property (@(posedge clk) disable iff (rst)
        (db_valid && en && full && !reg_wen) |=> qfull); // R6

    AST_ENQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (db_valid && en && !full) |=>
            (enq_ptr[OFS_W-1:0] == $past(enq_ptr[OFS_W-1:0]) + STEP) &&
            (enq_ptr[31:OFS_W] == $past(enq_ptr[31:OFS_W]))); // R3

    AST_EIQ_SET: assert property (@(posedge clk) disable iff (rst)
        ((enq_ptr != deq_ptr) && !reg_wen) |=> eiq); // R5

    AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
        (db_err && en && !reg_wen) |=> rxerr); // R7

    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en && !reg_wen) |=> ($stable(enq_ptr) && $stable(deq_ptr))); // R9

endmodule

bind dbell_queue dbell_queue_chk #(
    .OFS_W(OFS_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .db_valid(db_valid),
    .db_err  (db_err),
    .reg_wen (reg_wen),
    .en      (mode_en),
    .full    (ring_full),
    .eiq     (f_eiq),
    .qfull   (f_full),
    .rxerr   (f_err),
    .enq_ptr (enq_ptr),
    .deq_ptr (deq_ptr)
);

// File: tb/dbell_queue_tb_top.sv
`timescale 1ns/1ps
module dbell_queue_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        db_valid = 1'b0;
    logic [15:0] db_src = '0, db_tgt = '0, db_info = '0;
    logic        db_err = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_word = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  ring_ridx = '0;
    logic [63:0] ring_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbell_queue dut_i (
        .clk(clk), .rst(rst), .db_valid(db_valid), .db_src(db_src),
        .db_tgt(db_tgt), .db_info(db_info), .db_err(db_err),
        .reg_wen(reg_wen), .reg_word(reg_word), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ring_ridx(ring_ridx),
        .ring_rdata(ring_rdata), .irq(irq)
    );

    // {src, tgt, info}
    localparam logic [47:0] VEC [6] = '{
        48'h0001_0002_0003, 48'hFFFF_0000_8000, 48'h1234_5678_9ABC,
        48'hA5A5_5A5A_0F0F, 48'h0000_FFFF_FFFF, 48'h00FF_FF00_0001
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_db(input logic [15:0] s, input logic [15:0] t, input logic [15:0] i);
        db_valid = 1'b1; db_src = s; db_tgt = t; db_info = i;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic pulse_err();
        db_err = 1'b1;
        @(negedge clk);
        db_err = 1'b0;
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        reg_wen = 1'b1; reg_word = w; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        reg_word = w;
        #1 d = reg_rdata;
    endtask

    task automatic ring_rd(input logic [8:0] idx, output logic [63:0] d);
        ring_ridx = idx;
        @(negedge clk);
        d = ring_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] e;
        logic [63:0] wrap_entry;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 mode", v, 0);
        rd(2'd1, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 deq", v, 0);
        rd(2'd3, v); chk("R1 enq", v, 0);
        chk("R1 irq", irq, 0);

        // R9 disabled unit ignores doorbells and errors
        send_db(16'h1111, 16'h2222, 16'h3333);
        pulse_err();
        @(negedge clk);
        rd(2'd3, v); chk("R9 enq while disabled", v, 0);
        rd(2'd1, v); chk("R9 status while disabled", v, 0);

        // R9 pointer writes while disabled, with low bits forced to 0
        wr(2'd3, 32'h2000_0007);
        rd(2'd3, v); chk("R9 enq write aligned", v, 32'h2000_0000);
        wr(2'd2, 32'h2000_0000);
        wr(2'd0, 32'h1);
        wr(2'd3, 32'h0000_1234);
        rd(2'd3, v); chk("R9 enq write ignored when enabled", v, 32'h2000_0000);

        // R2 / R3 vector walk
        for (int i = 0; i < 6; i++) begin
            send_db(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
            rd(2'd3, v); chk("R3 enq advance", v, 32'h2000_0000 + 32'((i + 1) * 8));
            ring_rd(9'(i), e);
            chk("R2 entry layout", e, {16'h0, VEC[i][31:16], VEC[i][47:32], VEC[i][15:0]});
        end
        rd(2'd1, v); chk("R5 entry flag set", v, 32'h01);
        chk("R10 irq on entry", irq, 1);

        // R5 clear shows 0 for one cycle, then the flag is set again
        wr(2'd1, 32'h01);
        rd(2'd1, v); chk("R5 cleared", v, 0);
        @(negedge clk);
        rd(2'd1, v); chk("R5 reasserted", v, 32'h01);

        // R4 dequeue increment
        wr(2'd0, 32'h3);
        rd(2'd2, v); chk("R4 deq advance", v, 32'h2000_0008);
        rd(2'd0, v); chk("R4 bit1 reads 0", v, 32'h1);
        for (int i = 0; i < 5; i++) wr(2'd0, 32'h3);
        rd(2'd2, v); chk("R4 deq reaches enq", v, 32'h2000_0030);
        wr(2'd1, 32'h01);
        @(negedge clk); @(negedge clk);
        rd(2'd1, v); chk("R5 stays clear when empty", v, 0);
        chk("R10 irq low", irq, 0);
        wr(2'd0, 32'h3);
        rd(2'd2, v); chk("R4 empty dequeue ignored", v, 32'h2000_0030);

        // R7 / R8 error flag and write-one-to-clear
        pulse_err();
        rd(2'd1, v); chk("R7 error flag", v, 32'h80);
        chk("R10 irq on error", irq, 1);
        wr(2'd1, 32'h00);
        rd(2'd1, v); chk("R8 write zero no effect", v, 32'h80);
        wr(2'd1, 32'h91);
        rd(2'd1, v); chk("R8 clear all", v, 0);
        chk("R10 irq cleared", irq, 0);

        // R3 / R4 wrap at the 4 KB boundary keeps base bits
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h1000_0FF8);
        wr(2'd2, 32'h1000_0FF8);
        wr(2'd0, 32'h1);
        send_db(16'hCAFE, 16'hBEAD, 16'h7777);
        rd(2'd3, v); chk("R3 enq wrap", v, 32'h1000_0000);
        ring_rd(9'd511, wrap_entry);
        chk("R2 entry at last slot", wrap_entry, 64'h0000_BEAD_CAFE_7777);
        wr(2'd0, 32'h3);
        rd(2'd2, v); chk("R4 deq wrap", v, 32'h1000_0000);
        wr(2'd1, 32'h91);

        // R6 full ring: 511 entries, then a dropped doorbell
        wr(2'd0, 32'h0);
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h1);
        for (int i = 0; i < 511; i++) send_db(16'h0A0A, 16'h0505, 16'(i));
        rd(2'd3, v); chk("R6 enq at capacity", v, 32'h0000_0FF8);
        rd(2'd1, v); chk("R6 no full flag yet", v & 32'h10, 0);
        send_db(16'hDEAD, 16'hDEAD, 16'hBEEF);
        rd(2'd3, v); chk("R6 dropped enq unchanged", v, 32'h0000_0FF8);
        rd(2'd1, v); chk("R6 full flag", v & 32'h10, 32'h10);
        ring_rd(9'd511, e); chk("R6 spare slot untouched", e, wrap_entry);
        ring_rd(9'd510, e); chk("R2 last stored entry", e, 64'h0000_0505_0A0A_01FE);
        wr(2'd0, 32'h3);
        send_db(16'h0101, 16'h0202, 16'h01FF);
        rd(2'd3, v); chk("R3 enq wraps to base", v, 32'h0);
        ring_rd(9'd511, e); chk("R2 slot after free", e, 64'h0000_0202_0101_01FF);

        // R1 reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd2, v); chk("R1 deq after reset", v, 0);
        rd(2'd1, v); chk("R1 status after reset", v, 0);
        chk("R1 irq after reset", irq, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule